// File: doc/BRIEF.md
# SPI FIFO Status, Interrupt and DMA-Request Unit

This unit holds the transmit and receive FIFOs of an SPI controller and derives everything software and a DMA engine need to pace a transfer from them. It reports the word count in each FIFO and a five-bit status word. It keeps three sticky error flags: transmit overflow, receive overflow and receive underflow. It also forms two watermark conditions. These make up a five-bit raw interrupt vector, which is masked and combined into one interrupt line. Two DMA request lines are raised from separate watermarks.

The bus side pushes transmit words and pops receive words. The shift engine pops transmit words and pushes receive words. Four threshold registers, which may be written only while the controller is disabled, set the watermarks. A write of a value that is not below the FIFO depth is not retained, so software can find the depth by writing and reading back. Taking the controller enable low empties both FIFOs.

Top module: `spi_fifo_ctl`

## Requirements
- R1: `status` is {rx full, rx empty, tx empty, tx full, busy} from bit 4 down to bit 0. Busy is `eng_busy`, or the controller enabled with the transmit FIFO not empty. Status reflects the FIFO state one cycle after the push or pop edge.
- R2: Each FIFO returns words in push order. `tx_level` and `rx_level` count the stored words (0..DEPTH). Read data shows the oldest word.
- R3: A push into a full FIFO is dropped. A dropped transmit push sets raw bit 1, and a dropped receive push sets raw bit 3.
- R4: A receive pop while the receive FIFO is empty removes nothing and sets raw bit 2. Receive read data is zero whenever that FIFO is empty.
- R5: Raw bit 0 is set while tx level <= the transmit interrupt threshold. Raw bit 4 is set while rx level > the receive interrupt threshold.
- R6: A write with `clr_we` clears sticky flags: bit 0 clears all three, bit 1 clears receive underflow, bit 2 clears receive overflow, bit 3 clears transmit overflow. An error event in the same cycle wins over the clear.
- R7: `irq_masked` = `irq_raw` AND `irq_mask` (same bit layout). `irq` is the OR of `irq_masked`.
- R8: Threshold select codes are 0 tx interrupt, 1 rx interrupt, 2 tx DMA, 3 rx DMA. A write of a value >= DEPTH is not retained, and `thr_rdata` keeps the old value. All thresholds reset to 0.
- R9: Threshold writes while `ctl_en` is high are ignored.
- R10: While `ctl_en` is low, both FIFOs are emptied at each clock, and pushes and pops have no effect and flag no error.
- R11: `dma_en` bit 1 enables `tx_dreq`, which is high while enabled and tx level <= tx DMA watermark. `dma_en` bit 0 enables `rx_dreq`, which is high while enabled and rx level > rx DMA watermark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_en | input | 1 | Controller enable; low flushes both FIFOs |
| eng_busy | input | 1 | Shift engine active |
| tx_push | input | 1 | Bus-side transmit write strobe |
| tx_wdata | input | DW | Transmit word written |
| tx_pop | input | 1 | Engine takes a transmit word |
| tx_rdata | output | DW | Oldest transmit word (0 if empty) |
| rx_push | input | 1 | Engine stores a received word |
| rx_wdata | input | DW | Received word |
| rx_pop | input | 1 | Bus-side receive read strobe |
| rx_rdata | output | DW | Oldest received word (0 if empty) |
| thr_we | input | 1 | Threshold register write strobe |
| thr_wsel | input | 2 | Threshold register written |
| thr_wdata | input | REGW | Threshold write value |
| thr_rsel | input | 2 | Threshold register read |
| thr_rdata | output | REGW | Selected threshold value |
| irq_mask | input | 5 | Interrupt mask |
| clr_we | input | 1 | Clear register write strobe |
| clr_bits | input | 4 | Write-one-to-clear bits |
| dma_en | input | 2 | Bit 0 rx DMA enable, bit 1 tx DMA enable |
| status | output | 5 | Status word |
| irq_raw | output | 5 | Raw interrupt vector |
| irq_masked | output | 5 | Masked interrupt vector |
| irq | output | 1 | Combined interrupt |
| tx_dreq | output | 1 | Transmit DMA request |
| rx_dreq | output | 1 | Receive DMA request |
| tx_level | output | CW | Transmit FIFO word count |
| rx_level | output | CW | Receive FIFO word count |

## Verification
Every registered result is due exactly one clock after the edge that samples the stimulus. This covers levels, read data, status, sticky flags, watermark bits, DMA requests and threshold values. The mask, the DMA enables, `eng_busy` and the read select reach their outputs in the same cycle, through logic only. The bench drives inputs on the falling edge and updates its own FIFO and flag model at the next rising edge. It compares every output at the falling edge that follows, while the inputs are still held, so both kinds of path are sampled after they have settled and before anything new is applied.

// File: rtl/spi_fifo_pkg.sv
package spi_fifo_pkg;

    localparam int N_THR = 4;

    typedef struct packed {
        logic rx_full;
        logic rx_empty;
        logic tx_empty;
        logic tx_full;
        logic busy;
    } stat_t;

    typedef struct packed {
        logic rx_wm;
        logic rx_ovf;
        logic rx_unf;
        logic tx_ovf;
        logic tx_wm;
    } irq_vec_t;

    typedef struct packed {
        logic tx_ovf;
        logic rx_ovf;
        logic rx_unf;
        logic all;
    } clr_t;

    typedef enum logic [1:0] {
        SEL_TX_IRQ = 2'd0,
        SEL_RX_IRQ = 2'd1,
        SEL_TX_DMA = 2'd2,
        SEL_RX_DMA = 2'd3
    } thr_sel_e;

    // sticky flag: a new event wins over a clear in the same cycle
    function automatic logic sticky_next(logic q, logic set, logic clr);
        return set | (q & ~clr);
    endfunction

endpackage

// File: rtl/spi_fifo_buf.sv
module spi_fifo_buf #(
    parameter  int DEPTH = 8,
    parameter  int DW    = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] wdata,
    input  logic          pop,
    output logic [DW-1:0] rdata,
    output logic [CW-1:0] level,
    output logic          full,
    output logic          empty
);
    // DEPTH is a power of two so the pointers wrap by themselves
    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign full    = (level == CW'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push & ~full & ~flush;
    assign do_pop  = pop & ~empty & ~flush;
    assign rdata   = empty ? '0 : mem[rp];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp    <= '0;
            rp    <= '0;
            level <= '0;
        end else begin
            if (do_push) wp <= wp + AW'(1);
            if (do_pop)  rp <= rp + AW'(1);
            level <= level + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end
endmodule

// File: rtl/spi_fifo_thr.sv
module spi_fifo_thr import spi_fifo_pkg::*; #(
    parameter  int DEPTH = 8,
    parameter  int REGW  = 16,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            lock,
    input  logic            we,
    input  thr_sel_e        wsel,
    input  logic [REGW-1:0] wdata,
    input  thr_sel_e        rsel,
    output logic [REGW-1:0] rdata,
    output logic [CW-1:0]   thr_q [N_THR]
);
    logic fits;

    // values at or above the depth are not retained
    assign fits  = (wdata < REGW'(DEPTH));
    assign rdata = REGW'(thr_q[rsel]);

    for (genvar i = 0; i < N_THR; i++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                thr_q[i] <= '0;
            else if (we && !lock && fits && wsel == thr_sel_e'(i))
                thr_q[i] <= wdata[CW-1:0];
        end
    end
endmodule

// File: rtl/spi_fifo_irq.sv
module spi_fifo_irq import spi_fifo_pkg::*; (
    input  logic     clk,
    input  logic     rst,
    input  logic     ev_tx_ovf,
    input  logic     ev_rx_ovf,
    input  logic     ev_rx_unf,
    input  logic     tx_wm_hit,
    input  logic     rx_wm_hit,
    input  logic     clr_we,
    input  clr_t     clr,
    input  irq_vec_t mask,
    output irq_vec_t raw,
    output irq_vec_t masked,
    output logic     irq
);
    logic txo_q, rxo_q, rxu_q;
    clr_t clr_eff;

    assign clr_eff = clr_we ? clr : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            txo_q <= 1'b0;
            rxo_q <= 1'b0;
            rxu_q <= 1'b0;
        end else begin
            txo_q <= sticky_next(txo_q, ev_tx_ovf, clr_eff.all | clr_eff.tx_ovf);
            rxo_q <= sticky_next(rxo_q, ev_rx_ovf, clr_eff.all | clr_eff.rx_ovf);
            rxu_q <= sticky_next(rxu_q, ev_rx_unf, clr_eff.all | clr_eff.rx_unf);
        end
    end

    always_comb begin
        raw.tx_wm  = tx_wm_hit;
        raw.tx_ovf = txo_q;
        raw.rx_unf = rxu_q;
        raw.rx_ovf = rxo_q;
        raw.rx_wm  = rx_wm_hit;
        masked     = raw & mask;
        irq        = |masked;
    end
endmodule

// File: rtl/spi_fifo_ctl.sv
module spi_fifo_ctl import spi_fifo_pkg::*; #(
    parameter  int DEPTH = 8,
    parameter  int DW    = 16,
    parameter  int REGW  = 16,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ctl_en,
    input  logic            eng_busy,
    input  logic            tx_push,
    input  logic [DW-1:0]   tx_wdata,
    input  logic            tx_pop,
    output logic [DW-1:0]   tx_rdata,
    input  logic            rx_push,
    input  logic [DW-1:0]   rx_wdata,
    input  logic            rx_pop,
    output logic [DW-1:0]   rx_rdata,
    input  logic            thr_we,
    input  logic [1:0]      thr_wsel,
    input  logic [REGW-1:0] thr_wdata,
    input  logic [1:0]      thr_rsel,
    output logic [REGW-1:0] thr_rdata,
    input  logic [4:0]      irq_mask,
    input  logic            clr_we,
    input  logic [3:0]      clr_bits,
    input  logic [1:0]      dma_en,
    output logic [4:0]      status,
    output logic [4:0]      irq_raw,
    output logic [4:0]      irq_masked,
    output logic            irq,
    output logic            tx_dreq,
    output logic            rx_dreq,
    output logic [CW-1:0]   tx_level,
    output logic [CW-1:0]   rx_level
);
    logic          flush;
    logic          tx_full, tx_empty, rx_full, rx_empty;
    logic [CW-1:0] thr_q [N_THR];
    stat_t         stat_s;
    irq_vec_t      raw_s, masked_s;

    assign flush = ~ctl_en;

    spi_fifo_buf #(.DEPTH(DEPTH), .DW(DW)) u_txf (
        .clk(clk), .rst(rst), .flush(flush),
        .push(tx_push), .wdata(tx_wdata), .pop(tx_pop), .rdata(tx_rdata),
        .level(tx_level), .full(tx_full), .empty(tx_empty)
    );

    spi_fifo_buf #(.DEPTH(DEPTH), .DW(DW)) u_rxf (
        .clk(clk), .rst(rst), .flush(flush),
        .push(rx_push), .wdata(rx_wdata), .pop(rx_pop), .rdata(rx_rdata),
        .level(rx_level), .full(rx_full), .empty(rx_empty)
    );

    spi_fifo_thr #(.DEPTH(DEPTH), .REGW(REGW)) u_thr (
        .clk(clk), .rst(rst), .lock(ctl_en), .we(thr_we),
        .wsel(thr_sel_e'(thr_wsel)), .wdata(thr_wdata),
        .rsel(thr_sel_e'(thr_rsel)), .rdata(thr_rdata), .thr_q(thr_q)
    );

    spi_fifo_irq u_irq (
        .clk(clk), .rst(rst),
        .ev_tx_ovf(ctl_en & tx_push & tx_full),
        .ev_rx_ovf(ctl_en & rx_push & rx_full),
        .ev_rx_unf(ctl_en & rx_pop & rx_empty),
        .tx_wm_hit(tx_level <= thr_q[SEL_TX_IRQ]),
        .rx_wm_hit(rx_level > thr_q[SEL_RX_IRQ]),
        .clr_we(clr_we), .clr(clr_t'(clr_bits)), .mask(irq_vec_t'(irq_mask)),
        .raw(raw_s), .masked(masked_s), .irq(irq)
    );

    always_comb begin
        stat_s.busy     = eng_busy | (ctl_en & ~tx_empty);
        stat_s.tx_full  = tx_full;
        stat_s.tx_empty = tx_empty;
        stat_s.rx_empty = rx_empty;
        stat_s.rx_full  = rx_full;
    end

    assign status     = stat_s;
    assign irq_raw    = raw_s;
    assign irq_masked = masked_s;
    assign tx_dreq    = ctl_en & dma_en[1] & (tx_level <= thr_q[SEL_TX_DMA]);
    assign rx_dreq    = ctl_en & dma_en[0] & (rx_level > thr_q[SEL_RX_DMA]);
endmodule

// File: rtl/spi_fifo_ctl_chk.sv
module spi_fifo_ctl_chk #(
    parameter  int DEPTH = 8,
    parameter  int DW    = 16,
    parameter  int REGW  = 16,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input logic            clk,
    input logic            rst,
    input logic            ctl_en,
    input logic            tx_push,
    input logic            rx_push,
    input logic            rx_pop,
    input logic [DW-1:0]   rx_rdata,
    input logic [1:0]      thr_rsel,
    input logic [REGW-1:0] thr_rdata,
    input logic [4:0]      irq_mask,
    input logic            clr_we,
    input logic [3:0]      clr_bits,
    input logic [1:0]      dma_en,
    input logic [4:0]      status,
    input logic [4:0]      irq_raw,
    input logic [4:0]      irq_masked,
    input logic            irq,
    input logic            tx_dreq,
    input logic            rx_dreq,
    input logic [CW-1:0]   tx_level,
    input logic [CW-1:0]   rx_level
);
    AST_STATUS_TX_EMPTY: assert property (@(posedge clk) disable iff (rst)
        status[2] == (tx_level == '0)); // R1
    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (rst)
        (tx_level <= CW'(DEPTH)) && (rx_level <= CW'(DEPTH))); // R2
    AST_TXO_SET: assert property (@(posedge clk) disable iff (rst)
        ctl_en && tx_push && status[1] |=> irq_raw[1]); // R3
    AST_RXO_SET: assert property (@(posedge clk) disable iff (rst)
        ctl_en && rx_push && status[4] |=> irq_raw[3]); // R3
    AST_RXU_SET: assert property (@(posedge clk) disable iff (rst)
        ctl_en && rx_pop && status[3] |=> irq_raw[2]); // R4
    AST_RXU_ZERO: assert property (@(posedge clk) disable iff (rst)
        status[3] |-> rx_rdata == '0); // R4
    AST_CLR_ALL: assert property (@(posedge clk) disable iff (rst)
        clr_we && clr_bits[0] && !tx_push && !rx_push && !rx_pop |=> irq_raw[3:1] == 3'b000); // R6
    AST_MASK_ONLY: assert property (@(posedge clk) disable iff (rst)
        (irq_masked & ~irq_mask) == 5'b0); // R7
    AST_IRQ_LINE: assert property (@(posedge clk) disable iff (rst)
        irq == (irq_masked != 5'b0)); // R7
    AST_THR_LOCK: assert property (@(posedge clk) disable iff (rst)
        ctl_en |=> (thr_rsel != $past(thr_rsel)) || (thr_rdata == $past(thr_rdata))); // R9
    AST_FLUSH: assert property (@(posedge clk) disable iff (rst)
        !ctl_en |=> (tx_level == '0) && (rx_level == '0)); // R10
    AST_TX_DREQ_GATE: assert property (@(posedge clk) disable iff (rst)
        tx_dreq |-> ctl_en && dma_en[1]); // R11
    AST_RX_DREQ_GATE: assert property (@(posedge clk) disable iff (rst)
        rx_dreq |-> ctl_en && dma_en[0] && rx_level != '0); // R11
endmodule

bind spi_fifo_ctl spi_fifo_ctl_chk #(.DEPTH(DEPTH), .DW(DW), .REGW(REGW)) u_chk (.*);

// File: tb/tb_spi_fifo_ctl.sv
module tb_spi_fifo_ctl;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int DEPTH = 8;
    localparam int DW    = 16;
    localparam int REGW  = 16;
    localparam int CW    = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic            rst, ctl_en, eng_busy;
    logic            tx_push, tx_pop, rx_push, rx_pop;
    logic [DW-1:0]   tx_wdata, rx_wdata, tx_rdata, rx_rdata;
    logic            thr_we;
    logic [1:0]      thr_wsel, thr_rsel;
    logic [REGW-1:0] thr_wdata, thr_rdata;
    logic [4:0]      irq_mask;
    logic            clr_we;
    logic [3:0]      clr_bits;
    logic [1:0]      dma_en;
    logic [4:0]      status, irq_raw, irq_masked;
    logic            irq, tx_dreq, rx_dreq;
    logic [CW-1:0]   tx_level, rx_level;

    spi_fifo_ctl #(.DEPTH(DEPTH), .DW(DW), .REGW(REGW)) dut (.*);

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // reference model
    logic [DW-1:0] mtx[$];
    logic [DW-1:0] mrx[$];
    logic m_txo = 1'b0, m_rxo = 1'b0, m_rxu = 1'b0;
    int   mthr[4] = '{0, 0, 0, 0};

    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [4:0] exp_status();
        logic [4:0] s;
        s[0] = eng_busy | (ctl_en & (mtx.size() != 0));
        s[1] = (mtx.size() == DEPTH);
        s[2] = (mtx.size() == 0);
        s[3] = (mrx.size() == 0);
        s[4] = (mrx.size() == DEPTH);
        return s;
    endfunction

    function automatic logic [4:0] exp_raw();
        logic [4:0] r;
        r[0] = (mtx.size() <= mthr[0]);
        r[1] = m_txo;
        r[2] = m_rxu;
        r[3] = m_rxo;
        r[4] = (mrx.size() > mthr[1]);
        return r;
    endfunction

    task automatic check_all(string tag);
        logic [4:0] er;
        er = exp_raw();
        chk({tag, "/R1"}, "status", 32'(status), 32'(exp_status()));
        chk({tag, "/R2"}, "tx_level", 32'(tx_level), 32'(mtx.size()));
        chk({tag, "/R2"}, "rx_level", 32'(rx_level), 32'(mrx.size()));
        chk({tag, "/R2"}, "tx_rdata", 32'(tx_rdata), (mtx.size() != 0) ? 32'(mtx[0]) : 32'd0);
        chk({tag, "/R4"}, "rx_rdata", 32'(rx_rdata), (mrx.size() != 0) ? 32'(mrx[0]) : 32'd0);
        chk({tag, "/R5"}, "irq_raw", 32'(irq_raw), 32'(er));
        chk({tag, "/R7"}, "irq_masked", 32'(irq_masked), 32'(er & irq_mask));
        chk({tag, "/R7"}, "irq", 32'(irq), 32'(|(er & irq_mask)));
        chk({tag, "/R11"}, "tx_dreq", 32'(tx_dreq),
            32'(ctl_en && dma_en[1] && (mtx.size() <= mthr[2])));
        chk({tag, "/R11"}, "rx_dreq", 32'(rx_dreq),
            32'(ctl_en && dma_en[0] && (mrx.size() > mthr[3])));
        chk({tag, "/R8"}, "thr_rdata", 32'(thr_rdata), 32'(mthr[thr_rsel]));
    endtask

    task automatic model_update();
        logic ev_txo, ev_rxo, ev_rxu, tf, rf;
        ev_txo = 1'b0; ev_rxo = 1'b0; ev_rxu = 1'b0;
        if (!ctl_en) begin
            mtx.delete();
            mrx.delete();
        end else begin
            tf = (mtx.size() == DEPTH);
            rf = (mrx.size() == DEPTH);
            ev_txo = tx_push && tf;
            ev_rxo = rx_push && rf;
            ev_rxu = rx_pop && (mrx.size() == 0);
            if (tx_pop && mtx.size() != 0) void'(mtx.pop_front());
            if (tx_push && !tf) mtx.push_back(tx_wdata);
            if (rx_pop && mrx.size() != 0) void'(mrx.pop_front());
            if (rx_push && !rf) mrx.push_back(rx_wdata);
        end
        if (clr_we) begin
            if (clr_bits[0] || clr_bits[1]) m_rxu = 1'b0;
            if (clr_bits[0] || clr_bits[2]) m_rxo = 1'b0;
            if (clr_bits[0] || clr_bits[3]) m_txo = 1'b0;
        end
        m_txo = m_txo | ev_txo;
        m_rxo = m_rxo | ev_rxo;
        m_rxu = m_rxu | ev_rxu;
        if (thr_we && !ctl_en && thr_wdata < REGW'(DEPTH)) mthr[thr_wsel] = int'(thr_wdata);
    endtask

    task automatic strobes_off();
        tx_push = 0; tx_pop = 0; rx_push = 0; rx_pop = 0;
        thr_we = 0; clr_we = 0;
    endtask

    // one clock with the inputs already set, then check and release strobes
    task automatic cyc(string tag);
        @(posedge clk);
        model_update();
        @(negedge clk);
        check_all(tag);
        strobes_off();
    endtask

    task automatic thr_write(logic [1:0] sel, logic [REGW-1:0] v, string tag);
        thr_we = 1; thr_wsel = sel; thr_wdata = v; thr_rsel = sel;
        cyc(tag);
        cyc(tag);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        rst = 1; ctl_en = 0; eng_busy = 0;
        tx_wdata = '0; rx_wdata = '0; thr_wsel = '0; thr_wdata = '0; thr_rsel = '0;
        irq_mask = 5'h1f; clr_bits = '0; dma_en = 2'b11;
        strobes_off();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        check_all("R1");

        // threshold programming while disabled, including rejected values
        thr_write(2'd0, 16'd3, "R8");
        thr_write(2'd1, 16'd2, "R8");
        thr_write(2'd2, 16'd4, "R8");
        thr_write(2'd3, 16'd1, "R8");
        thr_write(2'd1, 16'(DEPTH), "R8");
        thr_write(2'd1, 16'd100, "R8");
        thr_write(2'd0, 16'(DEPTH - 1), "R8");
        thr_write(2'd0, 16'd3, "R8");

        // pushes while disabled have no effect
        tx_push = 1; tx_wdata = 16'hDEAD; rx_push = 1; rx_wdata = 16'hBEEF;
        cyc("R10");

        ctl_en = 1;
        cyc("R1");
        eng_busy = 1;
        cyc("R1");
        eng_busy = 0;

        // fill transmit FIFO past full
        for (int i = 0; i < DEPTH + 2; i++) begin
            tx_push = 1; tx_wdata = 16'(16'h1000 + i);
            cyc("R3");
        end
        // writes while enabled are ignored
        thr_write(2'd0, 16'd1, "R9");
        thr_write(2'd3, 16'd5, "R9");

        // drain transmit FIFO in order
        for (int i = 0; i < DEPTH + 1; i++) begin
            tx_pop = 1;
            cyc("R2");
        end

        // receive underflow then fill past full
        rx_pop = 1;
        cyc("R4");
        for (int i = 0; i < DEPTH + 1; i++) begin
            rx_push = 1; rx_wdata = 16'(16'h2000 + 3 * i);
            cyc("R5");
        end
        for (int i = 0; i < 3; i++) begin
            rx_pop = 1; rx_push = 1; rx_wdata = 16'(16'h3000 + i);
            cyc("R2");
        end

        // individual and global clears
        irq_mask = 5'b01010;
        clr_we = 1; clr_bits = 4'b0010;
        cyc("R6");
        clr_we = 1; clr_bits = 4'b0100;
        cyc("R6");
        clr_we = 1; clr_bits = 4'b1000; tx_push = 1; tx_wdata = 16'h4444;
        cyc("R6");
        for (int i = 0; i < DEPTH; i++) begin
            tx_push = 1; tx_wdata = 16'(16'h5000 + i);
            cyc("R3");
        end
        clr_we = 1; clr_bits = 4'b1000; tx_push = 1;
        cyc("R6");
        clr_we = 1; clr_bits = 4'b0001;
        cyc("R6");

        // disable with data present flushes
        dma_en = 2'b01;
        ctl_en = 0;
        cyc("R10");
        tx_push = 1; rx_pop = 1;
        cyc("R10");
        ctl_en = 1;
        cyc("R10");

        // constrained random traffic
        for (int n = 0; n < 4000; n++) begin
            ctl_en    = ($urandom % 48) != 0;
            eng_busy  = $urandom % 2;
            tx_push   = ($urandom % 3) != 0;
            tx_wdata  = 16'($urandom);
            tx_pop    = $urandom % 2;
            rx_push   = $urandom % 2;
            rx_wdata  = 16'($urandom);
            rx_pop    = ($urandom % 3) == 0;
            thr_we    = ($urandom % 4) == 0;
            thr_wsel  = 2'($urandom);
            thr_wdata = 16'($urandom % 12);
            thr_rsel  = 2'($urandom);
            irq_mask  = 5'($urandom);
            clr_we    = ($urandom % 8) == 0;
            clr_bits  = 4'($urandom);
            dma_en    = 2'($urandom);
            cyc("RND");
        end

        finish_run();
    end
endmodule